// File: doc/BRIEF.md
# Instruction Prefix Parser

This block sits at the front of a variable-length instruction decoder. It takes instruction bytes one per cycle through a valid/ready handshake and absorbs the leading prefix bytes. These are up to four legacy prefixes, followed by an optional register-extension prefix of the form `0100WRXB`. When it meets the first byte that is not a prefix, it presents that opcode byte on a held output together with the decoded attributes. The attributes are an operand-size override flag, an address-size override flag, the four extension bits, and the number of prefix bytes that came before the opcode.

The parser also counts every byte of the instruction and raises a fault when the instruction grows beyond the architectural limit of 15 bytes. The same fault is raised when a fifth legacy prefix arrives. Decoding of the opcode, addressing bytes, displacement and immediate is left to later stages. Those stages tell the parser where the instruction ends by raising `in_last` together with its final byte. This ends the instruction and returns the parser to prefix collection.

Top module: `prefix_parser`

## Requirements
- R1: After reset, `op_valid` is 0, `fault` is 0, `len_o` is 0 and `in_ready` is 1.
- R2: The bytes 0x66, 0x67, 0xF0, 0xF2 and 0xF3 are legacy prefixes, and up to four of them are accepted before the opcode. 0x66 sets `op_osz`, 0x67 sets `op_asz`, and the other three only add to the prefix count.
- R3: A byte from 0x40 to 0x4F is the extension prefix. Its bit 3 is reported as `op_w`, bit 2 as `op_r`, bit 1 as `op_x` and bit 0 as `op_b`. When two extension prefixes arrive in a row, the later one wins.
- R4: An extension prefix that is followed by a legacy prefix is discarded, so `op_w`, `op_r`, `op_x` and `op_b` read 0. It still counts as a prefix byte.
- R5: The first accepted byte that is neither a legacy prefix nor an extension prefix is the opcode. `op_valid` rises in the cycle after that byte is accepted, with `op_byte` equal to it and `op_npfx` equal to the number of prefix bytes before it.
- R6: While `op_valid` is 1 and `op_ready` is 0, the opcode output and its attributes stay unchanged and `in_ready` is 0. `op_valid` drops in the cycle after `op_ready` is seen, unless a new opcode is accepted in that same cycle.
- R7: `len_o` gives the number of bytes accepted so far in the current instruction, saturating at 16. It returns to 0 after a byte with `in_last` is accepted.
- R8: Accepting a 16th byte in one instruction sets `fault`. An instruction of exactly 15 bytes does not.
- R9: Accepting a fifth legacy prefix sets `fault`, and no opcode is emitted for that instruction.
- R10: Once set, `fault` stays at 1 until the first byte of the next instruction is accepted, and then clears.
- R11: Bytes after the opcode are not parsed as prefixes. A byte with `in_last` resets the prefix state, so the next instruction starts with no flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_last | input | 1 | This byte ends the instruction |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| op_ready | input | 1 | Consumer takes the opcode output |
| op_valid | output | 1 | Opcode output is valid |
| op_byte | output | 8 | First opcode byte |
| op_osz | output | 1 | Operand-size override seen |
| op_asz | output | 1 | Address-size override seen |
| op_w | output | 1 | Extension W bit (64-bit operand) |
| op_r | output | 1 | Extension R bit (reg field high bit) |
| op_x | output | 1 | Extension X bit (index field high bit) |
| op_b | output | 1 | Extension B bit (rm/opcode reg high bit) |
| op_npfx | output | 4 | Count of prefix bytes before the opcode |
| len_o | output | 5 | Running byte count of the current instruction |
| fault | output | 1 | Over-length or excess-prefix fault |

## Verification
The assertions check four properties on every cycle:
- a stalled opcode output blocks the input and holds its fields unchanged;
- the running length never passes its saturation value and returns to zero after a final byte;
- an opcode is never emitted together with a raised fault;
- a fifth legacy prefix always leaves the fault set.

Only the bench's scenarios can show that the decoded attributes are correct. They sweep every legacy-prefix count with rotating prefix choices, all sixteen extension values, and the discarded-extension ordering. They also show the exact 15/16-byte boundary of the length fault, the suppressed opcode after a fifth legacy prefix, and when the fault clears.

// File: rtl/prefix_parser.sv
module prefix_parser #(
  parameter int MAX_LEN    = 15,
  parameter int MAX_LEGACY = 4,
  localparam int LW = $clog2(MAX_LEN + 2),
  localparam int PW = $clog2(MAX_LEN + 1),
  localparam int CW = $clog2(MAX_LEGACY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          op_ready,
  output logic          op_valid,
  output logic [7:0]    op_byte,
  output logic          op_osz,
  output logic          op_asz,
  output logic          op_w,
  output logic          op_r,
  output logic          op_x,
  output logic          op_b,
  output logic [PW-1:0] op_npfx,
  output logic [LW-1:0] len_o,
  output logic          fault
);

  typedef enum logic [1:0] {S_PFX, S_BODY, S_DROP} st_t;

  st_t           st_q;
  logic [LW-1:0] len_q;
  logic [CW-1:0] leg_q;
  logic [PW-1:0] npfx_q;
  logic          osz_q, asz_q, flt_q;
  logic [3:0]    ext_q;
  logic          acc, is_leg, is_ext, over, leg_over, emit;

  assign in_ready = !op_valid || op_ready;
  assign acc      = in_valid && in_ready;
  assign is_ext   = in_byte[7:4] == 4'h4;
  assign over     = len_q >= LW'(MAX_LEN);
  assign leg_over = (st_q == S_PFX) && is_leg && (leg_q == CW'(MAX_LEGACY));
  assign emit     = acc && (st_q == S_PFX) && !is_leg && !is_ext && !over;
  assign len_o    = len_q;
  assign fault    = flt_q;

  always_comb begin
    case (in_byte)
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: is_leg = 1'b1;
      default:                           is_leg = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_PFX;
      len_q  <= '0;
      leg_q  <= '0;
      npfx_q <= '0;
      osz_q  <= 1'b0;
      asz_q  <= 1'b0;
      ext_q  <= 4'h0;
    end else if (acc) begin
      if (in_last) begin
        st_q   <= S_PFX;
        len_q  <= '0;
        leg_q  <= '0;
        npfx_q <= '0;
        osz_q  <= 1'b0;
        asz_q  <= 1'b0;
        ext_q  <= 4'h0;
      end else begin
        if (len_q != LW'(MAX_LEN + 1)) len_q <= len_q + 1'b1;
        if (st_q == S_PFX) begin
          if (over || leg_over) begin
            st_q <= S_DROP;
          end else if (is_leg) begin
            leg_q  <= leg_q + 1'b1;
            npfx_q <= npfx_q + 1'b1;
            ext_q  <= 4'h0;
            if (in_byte == 8'h66) osz_q <= 1'b1;
            if (in_byte == 8'h67) asz_q <= 1'b1;
          end else if (is_ext) begin
            npfx_q <= npfx_q + 1'b1;
            ext_q  <= in_byte[3:0];
          end else begin
            st_q <= S_BODY;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flt_q <= 1'b0;
    else if (acc) begin
      if (over || leg_over)      flt_q <= 1'b1;
      else if (len_q == '0)      flt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_byte  <= 8'h00;
      op_osz   <= 1'b0;
      op_asz   <= 1'b0;
      {op_w, op_r, op_x, op_b} <= 4'h0;
      op_npfx  <= '0;
    end else if (emit) begin
      op_valid <= 1'b1;
      op_byte  <= in_byte;
      op_osz   <= osz_q;
      op_asz   <= asz_q;
      {op_w, op_r, op_x, op_b} <= ext_q;
      op_npfx  <= npfx_q;
    end else if (op_ready) begin
      op_valid <= 1'b0;
    end
  end

  a_r6_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |-> !in_ready);

  a_r6_stall_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_byte) && $stable(op_npfx)
                              && $stable({op_osz, op_asz, op_w, op_r, op_x, op_b}));

  a_r7_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    len_o <= LW'(MAX_LEN + 1));

  a_r7_len_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> len_o == '0);

  a_r9_no_emit_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> !fault);

  a_r9_excess_prefix_faults: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && leg_over |=> fault);

endmodule

// File: tb/prefix_parser_tb.sv
`timescale 1ns/1ps
module prefix_parser_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, op_ready = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, op_valid, op_osz, op_asz, op_w, op_r, op_x, op_b, fault;
  logic [7:0] op_byte;
  logic [3:0] op_npfx;
  logic [4:0] len_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  prefix_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .in_ready(in_ready), .op_ready(op_ready), .op_valid(op_valid), .op_byte(op_byte),
    .op_osz(op_osz), .op_asz(op_asz), .op_w(op_w), .op_r(op_r), .op_x(op_x), .op_b(op_b),
    .op_npfx(op_npfx), .len_o(len_o), .fault(fault));

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_last = last;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  function automatic logic [7:0] leg_of(input int i);
    case (i % 5)
      0: return 8'h66;
      1: return 8'h67;
      2: return 8'hF0;
      3: return 8'hF2;
      default: return 8'hF3;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "op_valid", op_valid, 0);
    chk("R1", "fault", fault, 0);
    chk("R1", "len_o", len_o, 0);
    chk("R1", "in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R11: sweep legacy count, extension value and ordering
    for (int n = 0; n <= 4; n++) begin
      for (int v = 0; v < 18; v++) begin
        logic [7:0] seq [8];
        int cnt;
        int eosz, easz, ewrxb, enp;
        logic [7:0] opc;
        if (v == 17 && n == 0) continue;
        cnt = 0; eosz = 0; easz = 0; ewrxb = 0;
        for (int j = 0; j < n; j++) begin
          logic [7:0] lb;
          lb = leg_of(j + n + v);
          if (lb == 8'h66) eosz = 1;
          if (lb == 8'h67) easz = 1;
          if (v == 17 && j == n - 1) begin
            seq[cnt] = 8'h4F; cnt++;
          end
          seq[cnt] = lb; cnt++;
        end
        if (v >= 1 && v <= 16) begin
          seq[cnt] = 8'h40 + 8'(v - 1); cnt++;
          ewrxb = v - 1;
        end
        enp = cnt;
        opc = 8'h80 + 8'((n * 7 + v) & 63);
        for (int j = 0; j < cnt; j++) send(seq[j], 1'b0);
        send(opc, 1'b0);
        chk("R5", "op_valid", op_valid, 1);
        chk("R5", "op_byte", op_byte, opc);
        chk("R5", "op_npfx", op_npfx, enp);
        chk("R2", "op_osz", op_osz, eosz);
        chk("R2", "op_asz", op_asz, easz);
        chk(v == 17 ? "R4" : "R3", "wrxb", {op_w, op_r, op_x, op_b}, ewrxb);
        chk("R7", "len after opcode", len_o, enp + 1);
        send(8'h66, 1'b0);
        send(8'h48, 1'b1);
        chk("R11", "op_valid after body", op_valid, 0);
        chk("R7", "len after last", len_o, 0);
        chk("R8", "fault", fault, 0);
      end
    end

    // R11: body bytes 0x66/0x48 above must not leak into a bare opcode
    send(8'h90, 1'b1);
    chk("R11", "op_osz clean", op_osz, 0);
    chk("R11", "wrxb clean", {op_w, op_r, op_x, op_b}, 0);
    chk("R11", "op_npfx clean", op_npfx, 0);

    // R3: back-to-back extension prefixes, later wins
    send(8'h48, 1'b0); send(8'h41, 1'b0); send(8'h01, 1'b1);
    chk("R3", "later ext wins", {op_w, op_r, op_x, op_b}, 4'h1);
    chk("R3", "npfx two ext", op_npfx, 2);

    // R9 R10: fifth legacy prefix
    for (int j = 0; j < 5; j++) begin
      send(leg_of(j), 1'b0);
      chk("R9", "fault during prefixes", fault, j == 4 ? 1 : 0);
    end
    send(8'h89, 1'b0);
    chk("R9", "no opcode after fault", op_valid, 0);
    send(8'hC0, 1'b1);
    chk("R10", "fault held at end", fault, 1);
    @(negedge clk);
    chk("R10", "fault held idle", fault, 1);
    send(8'hC3, 1'b1);
    chk("R10", "fault cleared", fault, 0);
    chk("R10", "next opcode emitted", op_valid, 1);

    // R7 R8: length sweep 1..17
    for (int L = 1; L <= 17; L++) begin
      for (int k = 1; k <= L; k++) begin
        send(k == 1 ? 8'h0F : 8'(k), k == L);
        if (k < L) chk("R7", "running len", len_o, k);
        if (k == 15 && k < L) chk("R8", "no fault at 15", fault, 0);
      end
      chk("R8", "fault vs length", fault, L > 15 ? 1 : 0);
    end

    // R6: output stall
    @(negedge clk); op_ready = 1'b0;
    send(8'h90, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6", "held valid", op_valid, 1);
    chk("R6", "held byte", op_byte, 8'h90);
    chk("R6", "in_ready low", in_ready, 0);
    op_ready = 1'b1;
    #1;
    chk("R6", "in_ready released", in_ready, 1);
    @(posedge clk); #1;
    chk("R6", "valid drops", op_valid, 0);
    send(8'h00, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule